// File: doc/BRIEF.md
# Time-Slotted Serial Audio Frame Transmitter

This block is the sending half of a controller for a fixed-rate serial audio link. Every 256 periods of the bit clock it sends one frame on a single serial data line. The frame opens with a 16-bit tag slot, and twelve 20-bit data slots follow it. A frame marker, SYNC, rises at the start of each frame and stays high for the length of the tag phase. Both outputs change only on the rising edge of the bit clock. At the nominal 12.288 MHz bit clock this gives a 48 kHz frame rate.

On the parallel side the block takes one command address word, one command data word and ten PCM sample words, each with its own valid flag, plus a 2-bit codec identifier. The tag slot tells the far end which slots carry live data. Because of this, streams at lower sample rates can share the fixed frame by marking their slot valid only in some frames. All parallel inputs are captured together at the clock edge that raises SYNC, so software may change them at any time and each frame stays consistent.

Top module: `slink_frame_tx`

## Requirements
- R1: The frame period is 256 bit clocks: SYNC rises once every 256 rising edges of `clk`. The first rise comes on the first rising edge after reset is released.
- R2: SYNC is high for 16 consecutive clocks, starting with the edge that raises it, and low for the remaining 240.
- R3: The first frame bit, tag bit 15 (frame valid), is driven on the edge after the one that raised SYNC. It is 1 exactly when at least one of the twelve slot valid flags captured for that frame is 1.
- R4: Tag bits 14 down to 3 are sent next, in that order. Bit 14 is the valid flag of slot 1 (command address), bit 13 that of slot 2 (command data), and bit 12−k that of PCM word k (slot 3+k, k = 0..9). A 1 means the slot is valid.
- R5: Tag bit 2 is sent as 0. Tag bit 1 is `codec_id[1]` and tag bit 0 is `codec_id[0]`.
- R6: After the tag come slots 1 to 12 in ascending order, each 20 bits sent MSB (bit 19) first. Slot 1 is `cmd_addr`, slot 2 is `cmd_data`, and slot 3+k is `pcm_data[20k+19:20k]`.
- R7: A slot whose valid flag is 0 is sent as twenty zero bits, whatever its data input holds.
- R8: All data, valid and codec-id inputs are sampled at the rising edge that raises SYNC. Input changes made at any other time during a frame affect only the next frame.
- R9: While `rst` is high, `sync_o` and `sdo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr | input | 20 | Slot 1 word (command address) |
| cmd_addr_vld | input | 1 | Slot 1 valid flag |
| cmd_data | input | 20 | Slot 2 word (command data) |
| cmd_data_vld | input | 1 | Slot 2 valid flag |
| pcm_data | input | 200 | Ten PCM words; word k in bits 20k+19..20k feeds slot 3+k |
| pcm_vld | input | 10 | Valid flag of PCM word k in bit k |
| codec_id | input | 2 | Codec identifier placed in tag bits 1..0 |
| sync_o | output | 1 | Frame marker, high during the tag phase |
| sdo_o | output | 1 | Serial frame data |

## Verification
The hardest case to reach from the ports is an input change in the middle of a frame. The frame already on the line must keep the values captured at the SYNC edge, and only the next frame may carry the new ones. The bench waits for a SYNC rise, changes every data, valid and codec input partway through the data phase, and checks that the current frame carries the old values and the following frame the new ones. The bench also gives invalid slots non-zero data, so that zero filling and the frame-valid flag are checked against patterns that would show any leak of the raw inputs.

// File: rtl/slink_tx_pkg.sv
package slink_tx_pkg;

  // codec identifier width carried in the low tag bits
  localparam int CID_W = 2;

  // tag: frame-valid + one flag per data slot + one zero bit + codec id
  function automatic int tag_width(input int n_data);
    return n_data + 2 + CID_W;
  endfunction

  function automatic int frame_length(input int n_data, input int slot_w);
    return tag_width(n_data) + n_data * slot_w;
  endfunction

endpackage

// File: rtl/slink_tx_seq.sv
module slink_tx_seq #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int DATA_SLOTS = 12,
  parameter int FRAME_LEN  = 256,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int BIT_MAX   = (TAG_W > SLOT_W) ? TAG_W : SLOT_W,
  localparam int BW        = $clog2(BIT_MAX),
  localparam int SW        = $clog2(DATA_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          frame_start,
  output logic          sync_d,
  output logic [SW-1:0] slot_idx,
  output logic [BW-1:0] bit_idx
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic [BW-1:0]    bit_q, bit_d;

  // position counter: value after an edge is the edge number within the frame
  always_comb begin
    frame_start = (pos_q == POS_W'(FRAME_LEN - 1));
    pos_d       = frame_start ? '0 : pos_q + POS_W'(1);
    sync_d      = (pos_d < POS_W'(TAG_W));
  end

  // slot/bit pointer: names the frame bit to be driven at the next edge
  always_comb begin
    slot_d = slot_q;
    bit_d  = bit_q;
    if (bit_q != '0) begin
      bit_d = bit_q - BW'(1);
    end else if (slot_q == SW'(DATA_SLOTS)) begin
      slot_d = '0;
      bit_d  = BW'(TAG_W - 1);
    end else begin
      slot_d = slot_q + SW'(1);
      bit_d  = BW'(SLOT_W - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= POS_W'(FRAME_LEN - 1);
      slot_q <= SW'(DATA_SLOTS);
      bit_q  <= '0;
    end else begin
      pos_q  <= pos_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  assign slot_idx = slot_q;
  assign bit_idx  = bit_q;

endmodule

// File: rtl/slink_tx_bank.sv
module slink_tx_bank #(
  parameter int SLOT_W     = 20,
  parameter int DATA_SLOTS = 12,
  parameter int CID_W      = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         capture,
  input  logic [DATA_SLOTS*SLOT_W-1:0] slot_word,
  input  logic [DATA_SLOTS-1:0]        slot_vld,
  input  logic [CID_W-1:0]             cid,
  output logic [DATA_SLOTS*SLOT_W-1:0] word_q,
  output logic [DATA_SLOTS-1:0]        vld_q,
  output logic [CID_W-1:0]             cid_q
);

  // one capture register per slot; invalid slots are stored as zero
  for (genvar s = 0; s < DATA_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[s*SLOT_W +: SLOT_W] <= '0;
        vld_q[s]                   <= 1'b0;
      end else if (capture) begin
        word_q[s*SLOT_W +: SLOT_W] <= slot_vld[s] ? slot_word[s*SLOT_W +: SLOT_W]
                                                  : '0;
        vld_q[s]                   <= slot_vld[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cid_q <= '0;
    end else if (capture) begin
      cid_q <= cid;
    end
  end

endmodule

// File: rtl/slink_tx_tag.sv
module slink_tx_tag #(
  parameter int DATA_SLOTS = 12,
  parameter int CID_W      = 2,
  parameter int TAG_W      = 16
) (
  input  logic [DATA_SLOTS-1:0] vld,
  input  logic [CID_W-1:0]      cid,
  output logic [TAG_W-1:0]      tag
);

  // MSB: frame valid; then slot 1..N flags downward; then a zero; then cid
  assign tag[TAG_W-1] = |vld;

  for (genvar s = 0; s < DATA_SLOTS; s++) begin : g_flag
    assign tag[TAG_W-2-s] = vld[s];
  end

  assign tag[CID_W]        = 1'b0;
  assign tag[CID_W-1:0]    = cid;

endmodule

// File: rtl/slink_tx_mux.sv
module slink_tx_mux #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int DATA_SLOTS = 12,
  localparam int BIT_MAX   = (TAG_W > SLOT_W) ? TAG_W : SLOT_W,
  localparam int BW        = $clog2(BIT_MAX),
  localparam int SW        = $clog2(DATA_SLOTS + 1)
) (
  input  logic [TAG_W-1:0]             tag,
  input  logic [DATA_SLOTS*SLOT_W-1:0] words,
  input  logic [SW-1:0]                slot_idx,
  input  logic [BW-1:0]                bit_idx,
  output logic                         bit_o
);

  logic             tag_bit;
  logic [SLOT_W-1:0] sel_word;
  logic             word_bit;

  always_comb begin
    tag_bit = 1'b0;
    for (int i = 0; i < TAG_W; i++) begin
      if (bit_idx == BW'(i)) tag_bit = tag[i];
    end
  end

  always_comb begin
    sel_word = '0;
    for (int s = 0; s < DATA_SLOTS; s++) begin
      if (slot_idx == SW'(s + 1)) sel_word = words[s*SLOT_W +: SLOT_W];
    end
  end

  always_comb begin
    word_bit = 1'b0;
    for (int i = 0; i < SLOT_W; i++) begin
      if (bit_idx == BW'(i)) word_bit = sel_word[i];
    end
  end

  assign bit_o = (slot_idx == '0) ? tag_bit : word_bit;

endmodule

// File: rtl/slink_frame_tx.sv
module slink_frame_tx #(
  parameter int SLOT_W    = 20,
  parameter int NUM_PCM   = 10,
  localparam int CID_W      = slink_tx_pkg::CID_W,
  localparam int DATA_SLOTS = NUM_PCM + 2,
  localparam int TAG_W      = slink_tx_pkg::tag_width(DATA_SLOTS),
  localparam int FRAME_LEN  = slink_tx_pkg::frame_length(DATA_SLOTS, SLOT_W),
  localparam int BIT_MAX    = (TAG_W > SLOT_W) ? TAG_W : SLOT_W,
  localparam int BW         = $clog2(BIT_MAX),
  localparam int SW         = $clog2(DATA_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SLOT_W-1:0]         cmd_addr,
  input  logic                      cmd_addr_vld,
  input  logic [SLOT_W-1:0]         cmd_data,
  input  logic                      cmd_data_vld,
  input  logic [NUM_PCM*SLOT_W-1:0] pcm_data,
  input  logic [NUM_PCM-1:0]        pcm_vld,
  input  logic [CID_W-1:0]          codec_id,
  output logic                      sync_o,
  output logic                      sdo_o
);

  logic                         frame_start;
  logic                         sync_d;
  logic [SW-1:0]                slot_idx;
  logic [BW-1:0]                bit_idx;
  logic [DATA_SLOTS*SLOT_W-1:0] slot_word;
  logic [DATA_SLOTS-1:0]        slot_vld;
  logic [DATA_SLOTS*SLOT_W-1:0] bank_word;
  logic [DATA_SLOTS-1:0]        bank_vld;
  logic [CID_W-1:0]             bank_cid;
  logic [TAG_W-1:0]             tag;
  logic                         next_bit;

  // slot 1 in the lowest lane, slot 2 next, PCM words above
  assign slot_word = {pcm_data, cmd_data, cmd_addr};
  assign slot_vld  = {pcm_vld, cmd_data_vld, cmd_addr_vld};

  slink_tx_seq #(
    .TAG_W      (TAG_W),
    .SLOT_W     (SLOT_W),
    .DATA_SLOTS (DATA_SLOTS),
    .FRAME_LEN  (FRAME_LEN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .sync_d      (sync_d),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx)
  );

  slink_tx_bank #(
    .SLOT_W     (SLOT_W),
    .DATA_SLOTS (DATA_SLOTS),
    .CID_W      (CID_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .capture   (frame_start),
    .slot_word (slot_word),
    .slot_vld  (slot_vld),
    .cid       (codec_id),
    .word_q    (bank_word),
    .vld_q     (bank_vld),
    .cid_q     (bank_cid)
  );

  slink_tx_tag #(
    .DATA_SLOTS (DATA_SLOTS),
    .CID_W      (CID_W),
    .TAG_W      (TAG_W)
  ) u_tag (
    .vld (bank_vld),
    .cid (bank_cid),
    .tag (tag)
  );

  slink_tx_mux #(
    .TAG_W      (TAG_W),
    .SLOT_W     (SLOT_W),
    .DATA_SLOTS (DATA_SLOTS)
  ) u_mux (
    .tag      (tag),
    .words    (bank_word),
    .slot_idx (slot_idx),
    .bit_idx  (bit_idx),
    .bit_o    (next_bit)
  );

  // registered outputs; the last bit of a frame leaves on the capture edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else begin
      sync_o <= sync_d;
      sdo_o  <= next_bit;
    end
  end

endmodule

// File: rtl/slink_frame_tx_chk.sv
module slink_frame_tx_chk #(
  parameter int TAG_W      = 16,
  parameter int FRAME_LEN  = 256,
  parameter int DATA_SLOTS = 12,
  parameter int CID_W      = 2,
  localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sync_o,
  input logic                  sdo_o,
  input logic [DATA_SLOTS-1:0] vld_bank,
  input logic [CID_W-1:0]      cid_bank
);

  logic             sync_prev;
  logic             seen;
  logic [CNT_W-1:0] cnt;
  logic             rise_now;
  logic             vexp;
  logic             in_flags;

  // cnt = edges elapsed since the SYNC-raising edge, for the sampled outputs
  assign rise_now = sync_o && !sync_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev <= 1'b0;
      seen      <= 1'b0;
      cnt       <= '0;
    end else begin
      sync_prev <= sync_o;
      if (rise_now) begin
        seen <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (cnt < CNT_W'(FRAME_LEN)) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    vexp     = 1'b0;
    in_flags = 1'b0;
    for (int i = 0; i < DATA_SLOTS; i++) begin
      if (cnt == CNT_W'(i + 2)) begin
        vexp     = vld_bank[i];
        in_flags = 1'b1;
      end
    end
  end

  // R1
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_now && seen) |-> (cnt == CNT_W'(FRAME_LEN)));

  // R2
  sync_high_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && cnt < CNT_W'(TAG_W)) |-> sync_o);

  // R2
  sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && cnt >= CNT_W'(TAG_W) && cnt < CNT_W'(FRAME_LEN)) |-> !sync_o);

  // R3
  frame_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && cnt == CNT_W'(1)) |-> (sdo_o == |vld_bank));

  // R4
  slot_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && in_flags) |-> (sdo_o == vexp));

  // R5
  tag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && cnt == CNT_W'(TAG_W - 2)) |-> !sdo_o);

  // R5
  cid_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && cnt == CNT_W'(TAG_W - 1)) |-> (sdo_o == cid_bank[1]));

  // R5
  cid_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise_now && cnt == CNT_W'(TAG_W)) |-> (sdo_o == cid_bank[0]));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && cnt >= CNT_W'(2) && cnt < CNT_W'(FRAME_LEN)) |-> $stable(vld_bank));

endmodule

bind slink_frame_tx slink_frame_tx_chk #(
  .TAG_W      (TAG_W),
  .FRAME_LEN  (FRAME_LEN),
  .DATA_SLOTS (DATA_SLOTS),
  .CID_W      (CID_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_o   (sync_o),
  .sdo_o    (sdo_o),
  .vld_bank (bank_vld),
  .cid_bank (bank_cid)
);

// File: tb/tb_slink_frame_tx.sv
module tb_slink_frame_tx;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [19:0]  cmd_addr = '0;
  logic         cmd_addr_vld = 1'b0;
  logic [19:0]  cmd_data = '0;
  logic         cmd_data_vld = 1'b0;
  logic [199:0] pcm_data = '0;
  logic [9:0]   pcm_vld = '0;
  logic [1:0]   codec_id = '0;
  logic         sync_o;
  logic         sdo_o;

  int total = 0;
  int bad   = 0;
  bit at_rise = 1'b0;

  // pending values for a mid-frame change
  logic [19:0]  p_addr, p_data;
  logic         p_addr_v, p_data_v;
  logic [199:0] p_pcm;
  logic [9:0]   p_pcm_v;
  logic [1:0]   p_cid;

  slink_frame_tx dut (
    .clk          (clk),
    .rst          (rst),
    .cmd_addr     (cmd_addr),
    .cmd_addr_vld (cmd_addr_vld),
    .cmd_data     (cmd_data),
    .cmd_data_vld (cmd_data_vld),
    .pcm_data     (pcm_data),
    .pcm_vld      (pcm_vld),
    .codec_id     (codec_id),
    .sync_o       (sync_o),
    .sdo_o        (sdo_o)
  );

  always #5 clk = ~clk;

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete (act=hung exp=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected word of slot s (1..12) from the given inputs
  function automatic logic [19:0] exp_slot(input int s, input logic [19:0] a,
      input logic av, input logic [19:0] d, input logic dv,
      input logic [199:0] p, input logic [9:0] pv);
    if (s == 1) return av ? a : 20'h0;
    if (s == 2) return dv ? d : 20'h0;
    return pv[s-3] ? p[(s-3)*20 +: 20] : 20'h0;
  endfunction

  // capture one frame after a SYNC rise; optionally apply pending inputs at bit chg_at
  task automatic get_frame(output logic [255:0] f, input int chg_at);
    int hi;
    logic prev;
    if (!at_rise) begin
      prev = 1'b1;
      forever begin
        @(negedge clk);
        if (sync_o && !prev) break;
        prev = sync_o;
      end
    end
    hi = 1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      f[255-i] = sdo_o;
      if (i < 255 && sync_o) hi++;
      if (i == 254) prev = sync_o;
      if (i == chg_at) begin
        cmd_addr = p_addr; cmd_addr_vld = p_addr_v;
        cmd_data = p_data; cmd_data_vld = p_data_v;
        pcm_data = p_pcm;  pcm_vld = p_pcm_v; codec_id = p_cid;
      end
    end
    chk(hi == 16, "R2 sync high width", hi, 16);
    chk(sync_o && !prev, "R1 next sync rise after 256", {prev, sync_o}, 2'b01);
    at_rise = 1'b1;
  endtask

  task automatic check_frame(input logic [255:0] f, input string tagname,
      input logic [19:0] a, input logic av, input logic [19:0] d, input logic dv,
      input logic [199:0] p, input logic [9:0] pv, input logic [1:0] c);
    logic [11:0] v;
    v = {av, dv, pv[0], pv[1], pv[2], pv[3], pv[4], pv[5], pv[6], pv[7], pv[8], pv[9]};
    chk(f[255] == |v, {"R3 frame valid ", tagname}, f[255], |v);
    chk(f[254:243] == v, {"R4 slot flags ", tagname}, f[254:243], v);
    chk(f[242:240] == {1'b0, c}, {"R5 zero bit and codec id ", tagname},
        f[242:240], {1'b0, c});
    for (int s = 1; s <= 12; s++) begin
      logic [19:0] e;
      e = exp_slot(s, a, av, d, dv, p, pv);
      chk(f[239-(s-1)*20 -: 20] == e, {"R6/R7 slot word ", tagname},
          f[239-(s-1)*20 -: 20], e);
    end
  endtask

  function automatic logic [199:0] pcm_pattern(input logic [19:0] seed);
    logic [199:0] r;
    for (int k = 0; k < 10; k++) r[k*20 +: 20] = seed ^ (20'h01111 * (k + 1));
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sync_o == 1'b0 && sdo_o == 1'b0, "R9 outputs low in reset",
        {sync_o, sdo_o}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk(sync_o == 1'b1, "R1 sync rises on first edge after reset", sync_o, 1);
    at_rise = 1'b1;
  endtask

  task automatic apply(input logic [19:0] a, input logic av, input logic [19:0] d,
      input logic dv, input logic [199:0] p, input logic [9:0] pv, input logic [1:0] c);
    cmd_addr = a; cmd_addr_vld = av; cmd_data = d; cmd_data_vld = dv;
    pcm_data = p; pcm_vld = pv; codec_id = c;
    at_rise = 1'b0;
  endtask

  task automatic t_full_valid();
    logic [255:0] f;
    logic [199:0] p;
    p = pcm_pattern(20'hA5C3E);
    apply(20'h80123, 1, 20'h4F0F1, 1, p, 10'h3FF, 2'b10);
    get_frame(f, -1);
    check_frame(f, "all valid", 20'h80123, 1, 20'h4F0F1, 1, p, 10'h3FF, 2'b10);
  endtask

  task automatic t_sparse();
    logic [255:0] f;
    logic [199:0] p;
    p = pcm_pattern(20'hFFFFF);
    apply(20'h00001, 1, 20'hFFFFF, 0, p, 10'b1000000101, 2'b01);
    get_frame(f, -1);
    check_frame(f, "sparse", 20'h00001, 1, 20'hFFFFF, 0, p, 10'b1000000101, 2'b01);
  endtask

  task automatic t_none_valid();
    logic [255:0] f;
    logic [199:0] p;
    p = pcm_pattern(20'h7FFFE);
    apply(20'hFFFFF, 0, 20'hFFFFF, 0, p, 10'h000, 2'b11);
    get_frame(f, -1);
    check_frame(f, "none valid R7", 20'hFFFFF, 0, 20'hFFFFF, 0, p, 10'h000, 2'b11);
    chk(f[255:240] == 16'h0003, "R3 R5 tag with no valid slot", f[255:240], 16'h0003);
  endtask

  task automatic t_midframe();
    logic [255:0] f;
    logic [199:0] p0;
    p0 = pcm_pattern(20'h12345);
    apply(20'h0ABCD, 1, 20'h13579, 1, p0, 10'b0101010101, 2'b00);
    p_addr = 20'hFEDCB; p_addr_v = 0; p_data = 20'h2468A; p_data_v = 1;
    p_pcm = pcm_pattern(20'h5A5A5); p_pcm_v = 10'b1010101010; p_cid = 2'b11;
    get_frame(f, 100);
    check_frame(f, "R8 old frame", 20'h0ABCD, 1, 20'h13579, 1, p0, 10'b0101010101, 2'b00);
    get_frame(f, -1);
    check_frame(f, "R8 next frame", p_addr, p_addr_v, p_data, p_data_v, p_pcm, p_pcm_v, p_cid);
  endtask

  initial begin
    t_reset();
    t_full_valid();
    t_sparse();
    t_none_valid();
    t_midframe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule